// File: doc/BRIEF.md
# Byte-Wide Four-Stage Pipelined Processor Core

This block is a compact 8-bit processor core with four general-purpose registers and a four-stage pipeline (fetch, decode, execute, write-back). Instructions are single bytes. Instructions and data share one memory address bus and one memory data path, which has a read input, a write output and a write strobe. A small surrounding system attaches a memory model or array and reads a display byte that the core latches whenever software stores to a fixed address.

Results of register-writing instructions are forwarded from the execute and write-back stages into decode. A program therefore sees each result on the next instruction, including load results, store addresses, store data and jump targets. The condition flags are not forwarded. Software must place at least one non-ALU instruction between an ALU instruction and a conditional branch. The instruction directly after a jump or branch must be neither a load-immediate nor another jump or branch. The core does not detect a breach of either rule.

Top module: `oc_core`

## Requirements
- R1: Instruction bits [7:4] are the opcode, bits [3:2] the destination field D and bits [1:0] the source field S. Opcodes: 0 no-op, 1 LDI, 2 LD, 3 ST, 4 ADD, 5 INC, 6 NEG, 7 SUB, 8 JMP, 9 BRZ, A BRN. Opcodes B to F behave as no-ops, and unused fields have no effect.
- R2: ADD sets reg[D] to reg[D]+reg[S]. INC sets reg[D] to reg[D]+1. NEG sets reg[D] to 0-reg[S]. SUB sets reg[D] to reg[D]-reg[S]. All results are modulo 256.
- R3: Only ADD, INC, NEG and SUB update the flags. Z becomes 1 exactly when the 8-bit result is zero, and N becomes bit 7 of the result. All other instructions leave both flags unchanged.
- R4: LD sets reg[D] to mem[reg[S]]. ST writes reg[D] to mem[reg[S]]. LDI sets reg[D] to the byte that follows it and resumes fetch after that byte. Only ALU and load results write the register file.
- R5: Every register read sees the results of all earlier instructions, including the immediately preceding one. This covers ALU operands, load and store addresses, store data and jump targets.
- R6: JMP redirects fetch to reg[S]. BRZ does so only when Z=1, and BRN only when N=1. Otherwise execution continues in sequence.
- R7: The instruction directly after JMP, BRZ or BRN always executes once before the target, whether the branch is taken or not.
- R8: A store to address 0xFF loads the stored byte into disp_out. Stores to any other address leave disp_out unchanged.
- R9: While rst is high at a clock edge, the core clears the fetch address to 0x00, the instruction register to no-op, the flags, all four registers and disp_out. In the first cycle after reset, mem_addr=0x00 and mem_we=0.
- R10: The instruction fetched at an edge occupies decode in the following cycle. In that cycle LD and ST drive their data address on mem_addr, and ST raises mem_we with the data on mem_wdata. LDI reads its immediate byte at the fetch address. Each of these leaves a one-cycle fetch bubble. LD and ST do not advance the fetch address; LDI advances it past the immediate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 8 | Shared instruction/data address |
| mem_rdata | input | 8 | Byte read from mem_addr in the same cycle |
| mem_wdata | output | 8 | Store data, valid while mem_we is high |
| mem_we | output | 1 | Store strobe, memory written at the rising edge |
| disp_out | output | 8 | Memory-mapped display register |

## Verification
The instruction at address 0 is fetched at the first edge after reset. Its decode-cycle bus activity appears one cycle later. A load-immediate pushes the next fetch one cycle further back. In a directed sequence the bench samples mem_addr, mem_we and mem_wdata at falling edges, counting these cycles exactly (fetch of the immediate in cycle 1, bubble fetch in cycle 2, store strobe in cycle 3, resumed fetch in cycle 4). Architectural effects are compared against an instruction-level model in the bench. These effects are memory bytes at 0x80 to 0xFF, which include register dumps, and the display byte. The comparison is made after a run of 300 cycles, which exceeds the longest generated program and ends in a self-loop that leaves memory untouched.

// File: rtl/oc_pkg.sv
package oc_pkg;
    localparam int XLEN = 8;
    localparam int NREG = 4;
    localparam int RIDX = $clog2(NREG);
    localparam int OPW  = XLEN - 2 * RIDX;

    typedef logic [XLEN-1:0] word_t;
    typedef logic [RIDX-1:0] ridx_t;

    typedef enum logic [OPW-1:0] {
        OP_NOP = 4'h0, OP_LDI, OP_LD, OP_ST, OP_ADD, OP_INC,
        OP_NEG, OP_SUB, OP_JMP, OP_BRZ, OP_BRN
    } opc_t;

    typedef struct packed {
        opc_t  op;
        ridx_t rd;
        word_t a;
        word_t b;
    } exs_t;

    typedef struct packed {
        logic  we;
        ridx_t rd;
        word_t data;
    } wbs_t;

    function automatic logic is_alu(opc_t op);
        return op inside {OP_ADD, OP_INC, OP_NEG, OP_SUB};
    endfunction

    function automatic logic is_load(opc_t op);
        return op inside {OP_LD, OP_LDI};
    endfunction

    function automatic logic is_mem(opc_t op);
        return is_load(op) || (op == OP_ST);
    endfunction

    function automatic logic is_wr(opc_t op);
        return is_alu(op) || is_load(op);
    endfunction
endpackage

// File: rtl/oc_alu.sv
module oc_alu
    import oc_pkg::*;
(
    input  opc_t  op,
    input  word_t src_a,
    input  word_t src_d,
    output word_t y,
    output logic  zf,
    output logic  nf
);
    always_comb begin
        case (op)
            OP_ADD:  y = src_d + src_a;
            OP_INC:  y = src_d + word_t'(1);
            OP_NEG:  y = word_t'(0) - src_a;
            OP_SUB:  y = src_d - src_a;
            default: y = src_a;
        endcase
    end

    assign zf = (y == '0);
    assign nf = y[XLEN-1];
endmodule

// File: rtl/oc_fwd.sv
module oc_fwd
    import oc_pkg::*;
(
    input  ridx_t sel,
    input  logic  ex_wr,
    input  ridx_t ex_rd,
    input  word_t ex_val,
    input  logic  wb_wr,
    input  ridx_t wb_rd,
    input  word_t wb_val,
    input  word_t rf_val,
    output word_t val
);
    // Youngest producer wins: execute stage before write-back stage.
    always_comb begin
        if (ex_wr && (ex_rd == sel))      val = ex_val;
        else if (wb_wr && (wb_rd == sel)) val = wb_val;
        else                              val = rf_val;
    end
endmodule

// File: rtl/oc_regfile.sv
module oc_regfile
    import oc_pkg::*;
#(
    parameter int NRD = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  ridx_t                     wa,
    input  word_t                     wd,
    input  logic [NRD-1:0][RIDX-1:0]  ra,
    output logic [NRD-1:0][XLEN-1:0]  rdata
);
    logic [NREG-1:0][XLEN-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we) regs_d[wa] = wd;
    end

    always_ff @(posedge clk) begin
        if (rst) regs_q <= '0;
        else     regs_q <= regs_d;
    end

    for (genvar i = 0; i < NRD; i++) begin : g_rd
        assign rdata[i] = regs_q[ra[i]];
    end

    // R4: registers change only through the write-back port
    a_r4_rf_quiet: assert property (@(posedge clk) disable iff (rst)
        !we |=> regs_q == $past(regs_q));
    a_r4_rf_write: assert property (@(posedge clk) disable iff (rst)
        we |=> regs_q[$past(wa)] == $past(wd));
endmodule

// File: rtl/oc_core.sv
module oc_core
    import oc_pkg::*;
#(
    parameter word_t DISP_ADDR = '1
) (
    input  logic            clk,
    input  logic            rst,
    output logic [XLEN-1:0] mem_addr,
    input  logic [XLEN-1:0] mem_rdata,
    output logic [XLEN-1:0] mem_wdata,
    output logic            mem_we,
    output logic [XLEN-1:0] disp_out
);
    typedef struct packed {
        word_t iar;
        word_t ir;
        exs_t  ex;
        wbs_t  wb;
        logic  zf;
        logic  nf;
        word_t disp;
    } core_t;

    core_t q, d;

    opc_t  dop;
    ridx_t drd, dra;
    word_t alu_y, ex_res;
    logic  alu_z, alu_n;
    logic  take, ex_wr;
    word_t bus_addr;
    logic  bus_we;
    logic [1:0][RIDX-1:0] rf_sel;
    logic [1:0][XLEN-1:0] rf_val;
    logic [1:0][XLEN-1:0] opnd;   // [0] source field S, [1] destination field D

    assign dop       = opc_t'(q.ir[XLEN-1 -: OPW]);
    assign drd       = q.ir[2*RIDX-1 -: RIDX];
    assign dra       = q.ir[RIDX-1:0];
    assign rf_sel[0] = dra;
    assign rf_sel[1] = drd;

    oc_regfile #(.NRD(2)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (q.wb.we),
        .wa    (q.wb.rd),
        .wd    (q.wb.data),
        .ra    (rf_sel),
        .rdata (rf_val)
    );

    oc_alu u_alu (
        .op    (q.ex.op),
        .src_a (q.ex.a),
        .src_d (q.ex.b),
        .y     (alu_y),
        .zf    (alu_z),
        .nf    (alu_n)
    );

    assign ex_res = is_load(q.ex.op) ? q.ex.a : alu_y;
    assign ex_wr  = is_wr(q.ex.op);

    for (genvar p = 0; p < 2; p++) begin : g_fwd
        oc_fwd u_fwd (
            .sel    (rf_sel[p]),
            .ex_wr  (ex_wr),
            .ex_rd  (q.ex.rd),
            .ex_val (ex_res),
            .wb_wr  (q.wb.we),
            .wb_rd  (q.wb.rd),
            .wb_val (q.wb.data),
            .rf_val (rf_val[p]),
            .val    (opnd[p])
        );
    end

    always_comb begin
        d        = q;
        bus_addr = q.iar;
        bus_we   = 1'b0;
        take     = 1'b0;

        // decode stage: bus use and control transfer
        case (dop)
            OP_LD: bus_addr = opnd[0];
            OP_ST: begin
                bus_addr = opnd[0];
                bus_we   = 1'b1;
                if (opnd[0] == DISP_ADDR) d.disp = opnd[1];
            end
            OP_JMP:  take = 1'b1;
            OP_BRZ:  take = q.zf;
            OP_BRN:  take = q.nf;
            default: ;
        endcase

        // fetch stage: a bus-using decode turns the fetch into a bubble
        d.ir = is_mem(dop) ? word_t'(0) : mem_rdata;
        if ((dop == OP_LD) || (dop == OP_ST)) d.iar = q.iar;
        else                                  d.iar = q.iar + word_t'(1);
        if (take) d.iar = opnd[0];

        // decode -> execute staging, loaded every cycle
        d.ex.op = dop;
        d.ex.rd = drd;
        d.ex.a  = is_load(dop) ? mem_rdata : opnd[0];
        d.ex.b  = opnd[1];

        // execute -> write-back staging, loaded every cycle
        d.wb.we   = ex_wr;
        d.wb.rd   = q.ex.rd;
        d.wb.data = ex_res;
        if (is_alu(q.ex.op)) begin
            d.zf = alu_z;
            d.nf = alu_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign mem_addr  = bus_addr;
    assign mem_we    = bus_we;
    assign mem_wdata = opnd[1];
    assign disp_out  = q.disp;

    // R10: a bus-using instruction in decode leaves a bubble behind it
    a_r10_mem_bubble: assert property (@(posedge clk) disable iff (rst)
        is_mem(dop) |=> q.ir == '0);
    // R10: LD and ST hold the fetch address
    a_r10_iar_hold: assert property (@(posedge clk) disable iff (rst)
        ((dop == OP_LD) || (dop == OP_ST)) |=> q.iar == $past(q.iar));
    // R3: flags untouched by non-ALU instructions in execute
    a_r3_flag_hold: assert property (@(posedge clk) disable iff (rst)
        !is_alu(q.ex.op) |=> (q.zf == $past(q.zf)) && (q.nf == $past(q.nf)));
    // R3: flags agree with the staged ALU result
    a_r3_flag_track: assert property (@(posedge clk) disable iff (rst)
        is_alu(q.ex.op) |=> (q.zf == (q.wb.data == '0)) && (q.nf == q.wb.data[XLEN-1]));
    // R8: display changes only after a store strobe to the display address
    a_r8_disp_src: assert property (@(posedge clk) disable iff (rst)
        (disp_out != $past(disp_out)) |-> ($past(mem_we) && ($past(mem_addr) == DISP_ADDR)));
endmodule

// File: tb/test_oc_core.sv
`timescale 1ns/1ps
module test_oc_core;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] mem_addr, mem_rdata, mem_wdata, disp_out;
    logic       mem_we;

    logic [7:0] mem [256];
    logic [7:0] mm  [256];
    logic [7:0] img [256];
    logic [7:0] mdisp;
    int gp = 0;
    int nchk = 0, nfail = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

    oc_core i_oc_core (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .disp_out  (disp_out)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            nfail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("[TB] %0d tests run, %0d failed", nchk, nfail);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic emit(input logic [7:0] b);
        img[8'(gp)] = b;
        gp++;
    endtask

    task automatic ins(input logic [3:0] op, input logic [1:0] rd, input logic [1:0] ra);
        emit({op, rd, ra});
    endtask

    task automatic clear_img();
        for (int i = 0; i < 256; i++) img[i] = 8'($urandom);
        gp = 0;
    endtask

    // register dump to F0..F2, then a self-loop
    task automatic finish_prog(output logic [7:0] halt);
        ins(4'h1, 2'd3, 2'd0); emit(8'hF0); ins(4'h3, 2'd0, 2'd3);
        ins(4'h1, 2'd3, 2'd0); emit(8'hF1); ins(4'h3, 2'd1, 2'd3);
        ins(4'h1, 2'd3, 2'd0); emit(8'hF2); ins(4'h3, 2'd2, 2'd3);
        halt = 8'(gp);
        ins(4'h1, 2'd3, 2'd0); emit(halt); ins(4'h8, 2'd0, 2'd3); ins(4'h0, 2'd0, 2'd0);
    endtask

    // instruction-level reference: sequential semantics plus one delay slot
    task automatic model_run(input logic [7:0] halt);
        logic [7:0] r [4];
        logic [7:0] pc, tgt, iw, res, npc;
        logic [3:0] op;
        logic [1:0] fd, fs;
        logic zf, nf, pend, take;
        for (int i = 0; i < 4; i++) r[i] = 8'h00;
        zf = 1'b0; nf = 1'b0; pend = 1'b0; pc = 8'h00; tgt = 8'h00; mdisp = 8'h00;
        for (int s = 0; s < 4000 && pc != halt; s++) begin
            iw = mm[pc]; op = iw[7:4]; fd = iw[3:2]; fs = iw[1:0];
            npc = pc + 8'd1; take = 1'b0; res = 8'h00;
            case (op)
                4'h1: begin r[fd] = mm[npc]; npc = pc + 8'd2; end
                4'h2: r[fd] = mm[r[fs]];
                4'h3: begin mm[r[fs]] = r[fd]; if (r[fs] == 8'hFF) mdisp = r[fd]; end
                4'h4, 4'h5, 4'h6, 4'h7: begin
                    case (op)
                        4'h4:    res = r[fd] + r[fs];
                        4'h5:    res = r[fd] + 8'd1;
                        4'h6:    res = 8'h00 - r[fs];
                        default: res = r[fd] - r[fs];
                    endcase
                    r[fd] = res; zf = (res == 8'h00); nf = res[7];
                end
                4'h8: take = 1'b1;
                4'h9: take = zf;
                4'hA: take = nf;
                default: ;
            endcase
            if (pend) pc = tgt; else pc = npc;
            pend = take;
            if (take) tgt = r[fs];
        end
    endtask

    task automatic load_and_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 256; i++) begin mem[i] = img[i]; mm[i] = img[i]; end
    endtask

    task automatic run_prog(input logic [7:0] halt, input string tag);
        int bad;
        load_and_reset();
        model_run(halt);
        rst = 1'b0;
        repeat (300) @(negedge clk);
        bad = -1;
        for (int i = 128; i < 256; i++) if (bad < 0 && mem[i] !== mm[i]) bad = i;
        if (bad < 0) check({tag, " data region"}, 0, 0);
        else check($sformatf("%s data[%0h]", tag, bad), 32'(mem[bad]), 32'(mm[bad]));
        check({tag, " display"}, 32'(disp_out), 32'(mdisp));
    endtask

    task automatic gen_random(output logic [7:0] halt);
        int k, sk;
        logic [1:0] t;
        logic [3:0] bop;
        logic [7:0] tg;
        clear_img();
        while (gp < 'h58) begin
            k = $urandom_range(0, 9);
            case (k)
                0, 1, 2, 9: ins(4'($urandom_range(4, 7)), 2'($urandom), 2'($urandom));
                3: ins(($urandom % 2) ? 4'h0 : 4'($urandom_range(11, 15)), 2'($urandom), 2'($urandom));
                4: begin ins(4'h1, 2'($urandom), 2'($urandom)); emit(8'($urandom)); end
                5: ins(4'h2, 2'($urandom), 2'($urandom));
                6, 7: begin
                    t = 2'($urandom);
                    ins(4'h1, t, 2'd0); emit(8'h80 | 8'($urandom_range(0, 127)));
                    ins(4'h3, 2'($urandom), t);
                end
                default: begin
                    t = 2'($urandom); sk = $urandom_range(1, 3);
                    bop = 4'($urandom_range(8, 10));
                    tg = 8'(gp + 4 + sk);
                    ins(4'h1, t, 2'd0); emit(tg);
                    ins(bop, 2'd0, t);
                    if ($urandom % 2) ins(4'($urandom_range(4, 7)), 2'($urandom), 2'($urandom));
                    else ins(4'h0, 2'd0, 2'd0);
                    for (int j = 0; j < sk; j++) ins(4'($urandom_range(4, 7)), 2'($urandom), 2'($urandom));
                end
            endcase
        end
        finish_prog(halt);
    endtask

    initial begin
        logic [7:0] halt;
        process::self().srandom(32'd20240611);

        // R9 / R10: reset state and bus timing of LDI then ST
        clear_img();
        ins(4'h1, 2'd1, 2'd0); emit(8'h90);   // LDI r1,90
        ins(4'h3, 2'd0, 2'd1);                 // ST r0 -> [r1]
        finish_prog(halt);
        load_and_reset();
        check("R9 reset mem_we", 32'(mem_we), 0);
        check("R9 reset disp_out", 32'(disp_out), 0);
        rst = 1'b0;
        #1;
        check("R9 first fetch address", 32'(mem_addr), 0);
        @(negedge clk);
        check("R10 cycle1 immediate address", 32'(mem_addr), 32'h01);
        check("R10 cycle1 no strobe", 32'(mem_we), 0);
        @(negedge clk);
        check("R10 cycle2 fetch after bubble", 32'(mem_addr), 32'h02);
        @(negedge clk);
        check("R10 cycle3 store strobe", 32'(mem_we), 1);
        check("R10 R5 cycle3 store address forwarded", 32'(mem_addr), 32'h90);
        check("R10 R9 cycle3 store data from cleared reg", 32'(mem_wdata), 0);
        @(negedge clk);
        check("R10 cycle4 fetch resumes", 32'(mem_addr), 32'h03);
        check("R10 cycle4 strobe low", 32'(mem_we), 0);

        // R5 / R8: dependent chains, load after store, display store
        clear_img();
        ins(4'h1, 2'd0, 2'd0); emit(8'h81);   // LDI r0,81
        ins(4'h5, 2'd0, 2'd0);                 // INC r0 -> 82
        ins(4'h4, 2'd1, 2'd0);                 // ADD r1,r0 -> 82
        ins(4'h3, 2'd0, 2'd1);                 // ST r0 -> [82]
        ins(4'h2, 2'd2, 2'd1);                 // LD r2,[82] -> 82
        ins(4'h5, 2'd2, 2'd3);                 // INC r2 -> 83 (S field ignored)
        ins(4'h3, 2'd2, 2'd0);                 // ST r2 -> [82]
        ins(4'h1, 2'd3, 2'd0); emit(8'hFF);
        ins(4'h3, 2'd2, 2'd3);                 // display <- 83
        ins(4'h1, 2'd3, 2'd0); emit(8'h90);
        ins(4'h3, 2'd0, 2'd3);                 // [90] <- 82, display unchanged
        ins(4'hC, 2'd3, 2'd2);                 // reserved opcode acts as no-op
        finish_prog(halt);
        run_prog(halt, "R5 R8 R1 forwarding program");
        check("R8 display holds stored byte", 32'(disp_out), 32'h83);
        check("R5 R4 load-after-store chain", 32'(mem[8'h82]), 32'h83);
        check("R8 R5 other-address store", 32'(mem[8'h90]), 32'h82);
        check("R2 R5 dump r1", 32'(mem[8'hF1]), 32'h82);

        // R6 / R7 / R3: branches and delay slots
        clear_img();
        ins(4'h1, 2'd0, 2'd0); emit(8'h05);   // r0=05
        ins(4'h6, 2'd1, 2'd0);                 // NEG r1,r0 -> FB, N=1
        ins(4'h1, 2'd3, 2'd0); emit(8'(gp + 5));
        ins(4'hA, 2'd0, 2'd3);                 // BRN taken
        ins(4'h5, 2'd0, 2'd0);                 // slot: r0=06
        ins(4'h5, 2'd0, 2'd0);                 // skipped
        ins(4'h5, 2'd0, 2'd0);                 // skipped
        ins(4'h7, 2'd2, 2'd2);                 // SUB r2,r2 -> 0, Z=1
        ins(4'h1, 2'd1, 2'd0); emit(8'h44);   // non-ALU, flags kept
        ins(4'h1, 2'd3, 2'd0); emit(8'(gp + 4));
        ins(4'h9, 2'd0, 2'd3);                 // BRZ taken
        ins(4'h0, 2'd0, 2'd0);                 // slot
        ins(4'h5, 2'd0, 2'd0);                 // skipped
        ins(4'h1, 2'd3, 2'd0); emit(8'(gp + 4));
        ins(4'hA, 2'd0, 2'd3);                 // BRN not taken (N=0)
        ins(4'h5, 2'd0, 2'd0);                 // slot: r0=07
        ins(4'h5, 2'd0, 2'd0);                 // fall-through: r0=08
        ins(4'h1, 2'd3, 2'd0); emit(8'(gp + 4));
        ins(4'h8, 2'd0, 2'd3);                 // JMP
        ins(4'h5, 2'd2, 2'd0);                 // slot: r2=01
        ins(4'h5, 2'd2, 2'd0);                 // skipped
        finish_prog(halt);
        run_prog(halt, "R6 R7 R3 branch program");
        check("R6 R7 branch path count in r0", 32'(mem[8'hF0]), 32'h08);
        check("R4 R3 immediate load kept flags", 32'(mem[8'hF1]), 32'h44);
        check("R7 jump delay slot executed", 32'(mem[8'hF2]), 32'h01);

        // constrained random programs
        for (int n = 0; n < 30; n++) begin
            gen_random(halt);
            run_prog(halt, $sformatf("R1 R2 R3 R4 R5 R6 R7 R8 random %0d", n));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end
endmodule